// File: doc/BRIEF.md
# PLL Digital Lock Monitor

This block decides whether a phase-locked loop has settled by watching the two correction pulses of its phase-frequency detector. A fast sampling clock brings the up and down pulses, and the reference clock, through two flop stages. Each sampled cycle in which the two pulses disagree adds one count of phase error. At every rising reference edge the total for the reference period that just ended is compared against a programmable window. When enough windows in a row pass, the digital lock flag goes high. A single failing period drops the flag again.

Two further paths cover cases where the digital flag is not enough. A combinational active-low output shows the raw disagreement of the two pulses. An external integrator can smooth it into a level when the comparison frequency is outside the range the digital check suits. A watchdog counts sampling cycles since the last reference edge. If the reference stops, it forces the flag low, so a vanished reference cannot leave a stale lock indication.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset `lock_o` is 0. With both pulse inputs idle, `alock_n_o` is 1.
- R2: The error of a reference period is the number of sampling cycles, between two consecutive synchronised rising edges of `ref_in`, in which the synchronised `up_in` and `dn_in` differ. Up and down take the same two-stage path as the reference. `lock_o` changes only in the cycle after a reference edge or after a watchdog expiry.
- R3: A period is good when its error count is at most `cfg_err_win`. `lock_o` rises after N consecutive good periods, with N = 3 when `cfg_long_run` = 0 and N = 5 when `cfg_long_run` = 1. It rises on the third sampling edge after the sampling-clock negative edge at which `ref_in` rose to close the Nth good period.
- R4: A period whose error exceeds `cfg_err_win` clears the run of good periods and drops `lock_o` with the same latency as in R3.
- R5: An error equal to `cfg_err_win` is good. An error one count larger is bad, so a static offset just above the window keeps the lock low.
- R6: `alock_n_o` equals the inverted XOR of `up_in` and `dn_in`, with no register in the path.
- R7: If no synchronised reference edge arrives for `cfg_timeout` sampling cycles, `lock_o` is forced to 0 and the run is cleared.
- R8: The first reference edge after reset or after a watchdog expiry only opens a measurement period and gives no verdict.
- R9: Intervals where up and down are both high add no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference clock, treated as asynchronous data |
| up_in | input | 1 | Up pulse from the phase-frequency detector |
| dn_in | input | 1 | Down pulse from the phase-frequency detector |
| cfg_err_win | input | ACC_W (8) | Largest error count, in sampling cycles, that still counts as good |
| cfg_long_run | input | 1 | 0: three good periods needed, 1: five |
| cfg_timeout | input | TO_W (12) | Sampling cycles without a reference edge before the watchdog expires |
| lock_o | output | 1 | Digital lock flag |
| alock_n_o | output | 1 | Active-low raw phase-error pulse train |

## Verification
A miscounted error accumulator or run counter shows up at `lock_o` on the third sampling edge after the reference edge that closes the affected period. The symptom is either a lock one period early or late, or a lock that survives a period with one count too many. A watchdog that does not clear its state keeps `lock_o` high during a reference outage. It can also let the first period after the outage produce a verdict, which makes the flag return one period early. Constrained random widths around the window boundary, together with changes of the required run length, expose such faults within a few reference periods.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Number of consecutive good periods needed before lock is declared.
  function automatic int unsigned runs_needed(input logic long_run);
    return long_run ? 32'd5 : 32'd3;
  endfunction

  // A period is acceptable when its error count is inside the window.
  function automatic logic err_within(input int unsigned width, input int unsigned win);
    return width <= win;
  endfunction

  // Increment that stops at a limit.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

endpackage

// File: rtl/plm_sync.sv
module plm_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= 2'b00;
      else        st <= {st[0], d[b]};
    end
    assign q[b] = st[1];
  end
endmodule

// File: rtl/plm_err_meter.sv
module plm_err_meter
  import plm_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_s,
  input  logic             xor_s,
  input  logic             expired,
  output logic             ref_edge,
  output logic             primed,
  output logic [ACC_W-1:0] period_width
);
  localparam int unsigned ACC_MAX = (32'd1 << ACC_W) - 32'd1;

  logic             ref_d;
  logic [ACC_W-1:0] acc;

  assign ref_edge     = ref_s & ~ref_d;
  assign period_width = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d  <= 1'b0;
      acc    <= '0;
      primed <= 1'b0;
    end else begin
      ref_d <= ref_s;
      if (ref_edge) begin
        acc    <= xor_s ? ACC_W'(1) : '0;
        primed <= 1'b1;
      end else begin
        if (xor_s) acc <= ACC_W'(sat_inc(32'(acc), ACC_MAX));
        if (expired) primed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/plm_qualifier.sv
module plm_qualifier
  import plm_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             primed,
  input  logic             expired,
  input  logic [ACC_W-1:0] period_width,
  input  logic [ACC_W-1:0] cfg_err_win,
  input  logic             cfg_long_run,
  output logic             period_good,
  output logic [RUN_W-1:0] run_cnt,
  output logic             lock
);
  logic [RUN_W-1:0] next_run;

  assign period_good = err_within(32'(period_width), 32'(cfg_err_win));
  assign next_run    = period_good ?
                       RUN_W'(sat_inc(32'(run_cnt), runs_needed(cfg_long_run))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end else if (ref_edge && primed) begin
      run_cnt <= next_run;
      lock    <= 32'(next_run) >= runs_needed(cfg_long_run);
    end else if (expired) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end
  end
endmodule

// File: rtl/plm_ref_watchdog.sv
module plm_ref_watchdog
  import plm_pkg::*;
#(
  parameter int TO_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_edge,
  input  logic [TO_W-1:0] cfg_timeout,
  output logic            expired
);
  localparam int unsigned WD_MAX = (32'd1 << TO_W) - 32'd1;

  logic [TO_W-1:0] wd_cnt;

  assign expired = 32'(wd_cnt) >= 32'(cfg_timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wd_cnt <= '0;
    else if (ref_edge) wd_cnt <= '0;
    else               wd_cnt <= TO_W'(sat_inc(32'(wd_cnt), WD_MAX));
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int ACC_W = 8,
  parameter int RUN_W = 3,
  parameter int TO_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             up_in,
  input  logic             dn_in,
  input  logic [ACC_W-1:0] cfg_err_win,
  input  logic             cfg_long_run,
  input  logic [TO_W-1:0]  cfg_timeout,
  output logic             lock_o,
  output logic             alock_n_o
);
  logic [2:0]       sync_q;
  logic             ref_s, up_s, dn_s, xor_s;
  logic             ref_edge, primed, wd_expired, period_good;
  logic [ACC_W-1:0] period_width;
  logic [RUN_W-1:0] run_cnt;

  assign alock_n_o = ~(up_in ^ dn_in);

  plm_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ref_in, up_in, dn_in}), .q(sync_q)
  );
  assign {ref_s, up_s, dn_s} = sync_q;
  assign xor_s = up_s ^ dn_s;

  plm_err_meter #(.ACC_W(ACC_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_s(ref_s), .xor_s(xor_s),
    .expired(wd_expired), .ref_edge(ref_edge), .primed(primed),
    .period_width(period_width)
  );

  plm_ref_watchdog #(.TO_W(TO_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge),
    .cfg_timeout(cfg_timeout), .expired(wd_expired)
  );

  plm_qualifier #(.ACC_W(ACC_W), .RUN_W(RUN_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .primed(primed),
    .expired(wd_expired), .period_width(period_width),
    .cfg_err_win(cfg_err_win), .cfg_long_run(cfg_long_run),
    .period_good(period_good), .run_cnt(run_cnt), .lock(lock_o)
  );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int RUN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_edge,
  input logic             primed,
  input logic             period_good,
  input logic             wd_expired,
  input logic [RUN_W-1:0] run_cnt,
  input logic             lock_o
);
  a_r2_lock_only_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_edge && !wd_expired) |=> $stable(lock_o));

  a_r4_bad_period_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && primed && !period_good) |=> !lock_o);

  a_r3_rise_needs_good_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ref_edge && primed && period_good));

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_cnt) <= 32'd5);

  a_r7_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expired && !ref_edge) |=> !lock_o);

  a_r8_unprimed_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !lock_o);
endmodule

bind pll_lock_monitor plm_checker #(.RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .primed(primed),
  .period_good(period_good), .wd_expired(wd_expired),
  .run_cnt(run_cnt), .lock_o(lock_o)
);

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0, up_in = 1'b0, dn_in = 1'b0;
  logic [7:0] cfg_err_win = 8'd4;
  logic       cfg_long_run = 1'b0;
  logic [11:0] cfg_timeout = 12'd64;
  logic       lock_o, alock_n_o;

  int n_chk = 0, n_fail = 0;

  // bench-side model state
  bit m_primed = 0;
  int m_run = 0;
  bit m_lock = 0;
  int m_prev_w = 0;

  always #2 clk = ~clk;

  pll_lock_monitor u_pll_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .up_in(up_in), .dn_in(dn_in),
    .cfg_err_win(cfg_err_win), .cfg_long_run(cfg_long_run),
    .cfg_timeout(cfg_timeout), .lock_o(lock_o), .alock_n_o(alock_n_o)
  );

  function automatic int need_of(bit long_run);
    if (long_run) return 5;
    return 3;
  endfunction

  function automatic bit ok_width(int w, int win);
    return !(w > win);
  endfunction

  task automatic check(bit got, bit exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  // One reference period of 'period' sampling cycles, error width w,
  // followed by ov cycles where both pulses are high.
  task automatic run_period(int w, int ov, bit on_up, int period, string tag);
    bit lead, lag;
    if (m_primed) begin
      if (ok_width(m_prev_w, int'(cfg_err_win))) begin
        m_run = (m_run + 1 > need_of(cfg_long_run)) ? need_of(cfg_long_run) : m_run + 1;
      end else begin
        m_run = 0;
      end
      m_lock = (m_run >= need_of(cfg_long_run));
    end
    m_primed = 1;
    m_prev_w = w;
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      if (i == 3) check(lock_o, m_lock, tag);
      ref_in = (i < period / 2);
      lead = (i >= 2) && (i < 2 + w + ov);
      lag  = (i >= 2 + w) && (i < 2 + w + ov);
      up_in = on_up ? lead : lag;
      dn_in = on_up ? lag : lead;
      #1;
      if (i == 1) check(alock_n_o, 1'b1, "R6 idle pulses");
      if (i == 2 && w > 0) check(alock_n_o, 1'b0, "R6 error pulse");
      if (ov > 0 && i == 2 + w) check(alock_n_o, 1'b1, "R9 overlap high");
    end
  endtask

  task automatic lose_ref();
    int gap;
    gap = int'(cfg_timeout) - 40;
    repeat (gap) @(negedge clk);
    check(lock_o, m_lock, "R7 lock held before timeout");
    repeat (60) @(negedge clk);
    m_primed = 0; m_run = 0; m_lock = 0;
    check(lock_o, 1'b0, "R7 lock dropped on reference loss");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(lock_o, 1'b0, "R1 lock during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(lock_o, 1'b0, "R1 lock after reset");
    check(alock_n_o, 1'b1, "R1 analog idle");

    // R8: first edge only primes; R3: three good periods lock
    for (int k = 0; k < 5; k++) run_period(2, 0, k[0], 16, "R3/R8 short run");
    // R5 boundary: width equal to window is good, window+1 is bad
    run_period(4, 0, 1'b1, 16, "R5 width at window");
    run_period(5, 0, 1'b0, 16, "R5 width at window");
    run_period(1, 0, 1'b1, 16, "R4/R5 width above window");
    for (int k = 0; k < 3; k++) run_period(0, 5, 1'b1, 16, "R9 overlap no error");
    run_period(0, 0, 1'b0, 16, "R9 overlap no error");
    // R3 five-period mode
    cfg_long_run = 1'b1;
    for (int k = 0; k < 7; k++) run_period(3, 1, k[0], 20, "R3 long run");
    // R7 watchdog, then R8 re-priming after the outage
    lose_ref();
    for (int k = 0; k < 7; k++) run_period(1, 0, 1'b1, 16, "R8 after timeout");

    // constrained random phase
    cfg_err_win = 8'd2;
    for (int k = 0; k < 240; k++) begin
      int w, ov, per;
      if (k % 40 == 0) cfg_long_run = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) < 8) w = $urandom_range(0, int'(cfg_err_win));
      else w = int'(cfg_err_win) + $urandom_range(1, 3);
      ov  = $urandom_range(0, 3);
      per = w + ov + 6 + $urandom_range(0, 10);
      run_period(w, ov, ($urandom_range(0, 1) == 1), per, "R2/R3/R4 random");
    end
    lose_ref();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule